// File: doc/BRIEF.md
# Scatter/Gather List Sequencer

This block walks an array of 64-bit list entries held in a memory and turns each entry into one sub-transfer for a downstream data mover. A list command supplies the transfer direction, the local buffer start address, the upper half of every external address, the byte address and byte length of the entry array, and a tag. Entries are read one at a time through a plain read port. The upper external address word is shared by the whole list, and each entry supplies its own lower word. The local pointer packs the pieces back to back, so each sub-transfer starts where the previous one ended.

An entry can carry a flag that halts the walk once its own sub-transfer has been handed off. The block then raises a level event and fetches nothing more until software acknowledges. Software can therefore rewrite entries that have not yet been read. Once every sub-transfer of the list has reported completion, the block pulses a single done strobe that carries the list's tag. The block takes a new command only when idle.

Top module: `dma_list_seq`

## Requirements
- R1: While reset is held and just after it is released, `cmd_ready` is 1 and `mem_req`, `xfer_valid`, `stall_evt` and `list_done` are 0.
- R2: The number of entries is `cmd_list_bytes` divided by 8. Entry i is read from byte address `cmd_list_base + 8*i`, one `mem_req` per entry, in index order.
- R3: Entry layout: bit 63 is the halt flag, bits 62:47 are unused, bits 46:32 are the byte size and bits 31:0 are the lower external address. Each sub-transfer's `xfer_ext_addr` is `{cmd_ext_hi, bits 31:0}` and its `xfer_size` is bits 46:32.
- R4: The first sub-transfer's `xfer_local_addr` is `cmd_local_addr`. Each later one is the previous local address plus the previous size.
- R5: Every sub-transfer of a list carries the command's direction on `xfer_dir` and its tag on `xfer_tag`.
- R6: At most one entry is in flight. No `mem_req` is raised while a sub-transfer is being offered.
- R7: While `xfer_valid` is 1 and `xfer_ready` is 0, the offered sub-transfer stays valid and its fields do not change.
- R8: After the handshake of an entry whose halt flag is 1, `stall_evt` goes to 1. No entry is read and no sub-transfer is offered until a `stall_ack` is seen. This also applies when the flagged entry is the last one.
- R9: An entry that is rewritten in memory while the block is halted is issued with its rewritten contents after the acknowledge.
- R10: `list_done` is a one-cycle pulse, raised once per list and only after `xfer_done` has been seen once for every sub-transfer. `done_tag` then equals the command's tag.
- R11: A list of length 0 produces `list_done` without any read or sub-transfer.
- R12: `cmd_ready` is 0 from acceptance until completion. A command offered in that window is ignored: the running list gets no extra sub-transfer and no extra done pulse.
- R13: An entry of the largest legal size, 16384 bytes, is issued with that full size and advances the local pointer by 0x4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | List command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_dir | input | 1 | Direction applied to every sub-transfer |
| cmd_local_addr | input | LA_W | Local buffer start address |
| cmd_ext_hi | input | 32 | Upper external address word |
| cmd_list_base | input | LIST_AW | Byte address of the entry array |
| cmd_list_bytes | input | LEN_W | Byte length of the entry array |
| cmd_tag | input | TAG_W | Group tag |
| mem_req | output | 1 | One-cycle read request for one entry |
| mem_addr | output | LIST_AW | Byte address of the requested entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry contents |
| xfer_valid | output | 1 | Sub-transfer offered |
| xfer_ready | input | 1 | Data mover accepts the sub-transfer |
| xfer_dir | output | 1 | Sub-transfer direction |
| xfer_local_addr | output | LA_W | Sub-transfer local address |
| xfer_ext_addr | output | 64 | Sub-transfer external address |
| xfer_size | output | 15 | Sub-transfer byte count |
| xfer_tag | output | TAG_W | Sub-transfer tag |
| xfer_done | input | 1 | One sub-transfer finished |
| stall_evt | output | 1 | Halted at a flagged entry |
| stall_ack | input | 1 | Acknowledge, resume walking |
| list_done | output | 1 | Whole list finished (pulse) |
| done_tag | output | TAG_W | Tag of the finished list |

## Verification
The assertions assume that every entry read from memory is legal: its size is at most 16384 bytes, its low address is 16-byte aligned and the array base is 8-byte aligned. They also assume that `xfer_done` never arrives for more sub-transfers than have been accepted. The bench keeps to these limits. Its entry table holds only aligned addresses and sizes up to 0x4000. Its model of the data mover returns one completion for each accepted handshake, and it can hold completions back. The memory model answers each read two cycles later. A throttled ready pattern exercises the hold rule, and a rewrite of an entry during a halt exercises the late-fetch rule.

// File: rtl/dls_pkg.sv
package dls_pkg;

   localparam int ENTRY_W  = 64;
   localparam int SIZE_W   = 15;
   localparam int LOW_W    = 32;
   localparam int MAX_XFER = 16384;

   typedef struct packed {
      logic              halt;
      logic [15:0]       unused;
      logic [SIZE_W-1:0] size;
      logic [LOW_W-1:0]  low_addr;
   } list_entry_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_ISSUE,
      ST_HALT,
      ST_DRAIN
   } seq_state_e;

endpackage

// File: rtl/dls_ptr.sv
module dls_ptr
   import dls_pkg::*;
#(
   parameter int LA_W    = 18,
   parameter int LIST_AW = 18,
   parameter int CNT_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LIST_AW-1:0] base,
   input  logic [LA_W-1:0]    start_la,
   input  logic               step,
   input  logic [SIZE_W-1:0]  step_size,
   output logic [LA_W-1:0]    local_addr,
   output logic [LIST_AW-1:0] entry_addr,
   output logic [CNT_W-1:0]   index
);

   localparam int STRIDE = ENTRY_W / 8;

   logic [LA_W-1:0] size_ext;

   generate
      if (LA_W >= SIZE_W) begin : g_zext
         assign size_ext = {{(LA_W-SIZE_W){1'b0}}, step_size};
      end else begin : g_trunc
         assign size_ext = step_size[LA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         local_addr <= '0;
         entry_addr <= '0;
         index      <= '0;
      end else if (load) begin
         local_addr <= start_la;
         entry_addr <= base;
         index      <= '0;
      end else if (step) begin
         local_addr <= local_addr + size_ext;
         entry_addr <= entry_addr + LIST_AW'(STRIDE);
         index      <= index + 1'b1;
      end
   end

endmodule

// File: rtl/dls_cmpl.sv
module dls_cmpl #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic             done_in,
   input  logic [CNT_W-1:0] target,
   output logic             all_done
);

   logic [CNT_W-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         seen_q <= '0;
      else if (active && done_in)
         seen_q <= seen_q + 1'b1;
   end

   assign all_done = (seen_q == target);

endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl
   import dls_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_fire,
   input  logic       list_empty,
   input  logic       mem_rvalid,
   input  logic       xfer_ready,
   input  logic       entry_halt,
   input  logic       entry_last,
   input  logic       at_end,
   input  logic       stall_ack,
   input  logic       all_done,
   output seq_state_e state_q,
   output logic       load,
   output logic       step,
   output logic       capture,
   output logic       mem_req,
   output logic       xfer_valid,
   output logic       stall_evt,
   output logic       list_done
);

   seq_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (cmd_fire) state_d = list_empty ? ST_DRAIN : ST_FETCH;
         ST_FETCH: state_d = ST_WAIT;
         ST_WAIT:  if (mem_rvalid) state_d = ST_ISSUE;
         ST_ISSUE: begin
            if (xfer_ready) begin
               if (entry_halt)      state_d = ST_HALT;
               else if (entry_last) state_d = ST_DRAIN;
               else                 state_d = ST_FETCH;
            end
         end
         ST_HALT:  if (stall_ack) state_d = at_end ? ST_DRAIN : ST_FETCH;
         ST_DRAIN: if (all_done) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign load       = (state_q == ST_IDLE) && cmd_fire;
   assign step       = (state_q == ST_ISSUE) && xfer_ready;
   assign capture    = (state_q == ST_WAIT) && mem_rvalid;
   assign mem_req    = (state_q == ST_FETCH);
   assign xfer_valid = (state_q == ST_ISSUE);
   assign stall_evt  = (state_q == ST_HALT);
   assign list_done  = (state_q == ST_DRAIN) && all_done;

endmodule

// File: rtl/dma_list_seq.sv
module dma_list_seq
   import dls_pkg::*;
#(
   parameter int  LA_W      = 18,
   parameter int  LIST_AW   = 18,
   parameter int  TAG_W     = 5,
   parameter int  MAX_ELEMS = 2048,
   localparam int LEN_W     = $clog2(MAX_ELEMS * 8) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic               cmd_dir,
   input  logic [LA_W-1:0]    cmd_local_addr,
   input  logic [31:0]        cmd_ext_hi,
   input  logic [LIST_AW-1:0] cmd_list_base,
   input  logic [LEN_W-1:0]   cmd_list_bytes,
   input  logic [TAG_W-1:0]   cmd_tag,
   output logic               mem_req,
   output logic [LIST_AW-1:0] mem_addr,
   input  logic               mem_rvalid,
   input  logic [63:0]        mem_rdata,
   output logic               xfer_valid,
   input  logic               xfer_ready,
   output logic               xfer_dir,
   output logic [LA_W-1:0]    xfer_local_addr,
   output logic [63:0]        xfer_ext_addr,
   output logic [14:0]        xfer_size,
   output logic [TAG_W-1:0]   xfer_tag,
   input  logic               xfer_done,
   output logic               stall_evt,
   input  logic               stall_ack,
   output logic               list_done,
   output logic [TAG_W-1:0]   done_tag
);

   localparam int CNT_W = LEN_W - 3;

   generate
      if (MAX_ELEMS < 1) begin : g_bad_depth
         $error("MAX_ELEMS must be at least 1");
      end
      if (TAG_W < 1 || TAG_W > 16) begin : g_bad_tag
         $error("TAG_W out of range");
      end
      if (LIST_AW < 4) begin : g_bad_aw
         $error("LIST_AW too narrow for 8-byte entries");
      end
   endgenerate

   seq_state_e       state_q;
   logic             load, step, capture, all_done;
   logic             dir_q;
   logic [31:0]      hi_q;
   logic [TAG_W-1:0] tag_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] index;
   list_entry_t      entry_q;
   logic [CNT_W-1:0] list_count;
   logic             cmd_fire;

   assign cmd_ready  = (state_q == ST_IDLE);
   assign cmd_fire   = cmd_valid && cmd_ready;
   assign list_count = cmd_list_bytes[LEN_W-1:3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= 1'b0;
         hi_q    <= '0;
         tag_q   <= '0;
         count_q <= '0;
      end else if (load) begin
         dir_q   <= cmd_dir;
         hi_q    <= cmd_ext_hi;
         tag_q   <= cmd_tag;
         count_q <= list_count;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       entry_q <= '0;
      else if (capture) entry_q <= list_entry_t'(mem_rdata);
   end

   dls_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_fire   (cmd_fire),
      .list_empty (list_count == '0),
      .mem_rvalid (mem_rvalid),
      .xfer_ready (xfer_ready),
      .entry_halt (entry_q.halt),
      .entry_last (index + 1'b1 == count_q),
      .at_end     (index == count_q),
      .stall_ack  (stall_ack),
      .all_done   (all_done),
      .state_q    (state_q),
      .load       (load),
      .step       (step),
      .capture    (capture),
      .mem_req    (mem_req),
      .xfer_valid (xfer_valid),
      .stall_evt  (stall_evt),
      .list_done  (list_done)
   );

   dls_ptr #(
      .LA_W    (LA_W),
      .LIST_AW (LIST_AW),
      .CNT_W   (CNT_W)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .base       (cmd_list_base),
      .start_la   (cmd_local_addr),
      .step       (step),
      .step_size  (entry_q.size),
      .local_addr (xfer_local_addr),
      .entry_addr (mem_addr),
      .index      (index)
   );

   dls_cmpl #(
      .CNT_W (CNT_W)
   ) u_cmpl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (load),
      .active   (state_q != ST_IDLE),
      .done_in  (xfer_done),
      .target   (count_q),
      .all_done (all_done)
   );

   assign xfer_dir      = dir_q;
   assign xfer_tag      = tag_q;
   assign xfer_ext_addr = {hi_q, entry_q.low_addr};
   assign xfer_size     = entry_q.size;
   assign done_tag      = tag_q;

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
   parameter int LA_W = 18
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            cmd_ready,
   input logic            mem_req,
   input logic            xfer_valid,
   input logic            xfer_ready,
   input logic [LA_W-1:0] xfer_local_addr,
   input logic [63:0]     xfer_ext_addr,
   input logic [14:0]     xfer_size,
   input logic            stall_evt,
   input logic            list_done
);

   a_r6_no_fetch_while_offering: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !xfer_valid);

   a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_ext_addr)
         && $stable(xfer_local_addr) && $stable(xfer_size)));

   a_r8_quiet_while_halted: assert property (@(posedge clk) disable iff (!rst_n)
      stall_evt |-> (!mem_req && !xfer_valid));

   a_r10_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |=> !list_done);

   a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   a_r13_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (xfer_size <= 15'd16384));

endmodule

bind dma_list_seq dls_checker #(.LA_W(LA_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cmd_valid       (cmd_valid),
   .cmd_ready       (cmd_ready),
   .mem_req         (mem_req),
   .xfer_valid      (xfer_valid),
   .xfer_ready      (xfer_ready),
   .xfer_local_addr (xfer_local_addr),
   .xfer_ext_addr   (xfer_ext_addr),
   .xfer_size       (xfer_size),
   .stall_evt       (stall_evt),
   .list_done       (list_done)
);

// File: tb/dma_list_seq_tb_top.sv
module dma_list_seq_tb_top;

   localparam int LA_W    = 18;
   localparam int LIST_AW = 18;
   localparam int TAG_W   = 5;
   localparam int LEN_W   = 15;

   typedef struct packed {
      logic        halt;
      logic [14:0] size;
      logic [31:0] low;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{1'b0, 15'd16,    32'h0000_1000},
      '{1'b0, 15'd128,   32'h0000_2010},
      '{1'b0, 15'd16384, 32'h8000_0000},
      '{1'b0, 15'd48,    32'hFFFF_FFF0},
      '{1'b0, 15'd32,    32'h0000_0040},
      '{1'b1, 15'd64,    32'h1234_5670},
      '{1'b0, 15'd16,    32'h0000_0100}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic               cmd_valid = 1'b0, cmd_ready, cmd_dir = 1'b0;
   logic [LA_W-1:0]    cmd_local_addr = '0;
   logic [31:0]        cmd_ext_hi = '0;
   logic [LIST_AW-1:0] cmd_list_base = '0;
   logic [LEN_W-1:0]   cmd_list_bytes = '0;
   logic [TAG_W-1:0]   cmd_tag = '0;
   logic               mem_req, mem_rvalid = 1'b0;
   logic [LIST_AW-1:0] mem_addr;
   logic [63:0]        mem_rdata = '0;
   logic               xfer_valid, xfer_ready = 1'b0, xfer_dir, xfer_done = 1'b0;
   logic [LA_W-1:0]    xfer_local_addr;
   logic [63:0]        xfer_ext_addr;
   logic [14:0]        xfer_size;
   logic [TAG_W-1:0]   xfer_tag, done_tag;
   logic               stall_evt, stall_ack = 1'b0, list_done;

   dma_list_seq dut_i (.*);

   logic [63:0]        mem [128];
   int                 checks = 0, fails = 0;
   int                 cyc = 0, ready_mode = 0;
   bit                 done_en = 1'b1;
   int                 pend = 0, rd_cnt = 0, rd_idx = 0;
   int                 n_cap = 0, n_fetch = 0, ld_cnt = 0, ld_pend = 0;
   int                 hold_bad = 0, hold_cycles = 0;
   logic [TAG_W-1:0]   ld_tag = '0;
   logic [LA_W-1:0]    cap_la [16];
   logic [63:0]        cap_ea [16];
   logic [14:0]        cap_sz [16];
   logic               cap_dir [16];
   logic [TAG_W-1:0]   cap_tag [16];
   logic [LIST_AW-1:0] cap_ma [16];
   bit                 prev_wait = 1'b0;
   logic [LA_W-1:0]    pv_la;
   logic [63:0]        pv_ea;
   logic [14:0]        pv_sz;

   // bench-side models, evaluated 1 ns after each falling edge
   always begin
      @(negedge clk);
      #1;
      cyc++;
      xfer_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (prev_wait && (!xfer_valid || xfer_la_changed()))
         hold_bad++;
      prev_wait = xfer_valid && !xfer_ready;
      if (prev_wait) begin
         hold_cycles++;
         pv_la = xfer_local_addr; pv_ea = xfer_ext_addr; pv_sz = xfer_size;
      end
      if (done_en && pend > 0 && !xfer_done) begin
         xfer_done = 1'b1; pend--;
      end else
         xfer_done = 1'b0;
      if (xfer_valid && xfer_ready) begin
         cap_la[n_cap] = xfer_local_addr; cap_ea[n_cap] = xfer_ext_addr;
         cap_sz[n_cap] = xfer_size; cap_dir[n_cap] = xfer_dir;
         cap_tag[n_cap] = xfer_tag;
         n_cap++; pend++;
      end
      mem_rvalid = 1'b0;
      if (rd_cnt > 0) begin
         rd_cnt--;
         if (rd_cnt == 0) begin
            mem_rvalid = 1'b1; mem_rdata = mem[rd_idx];
         end
      end
      if (mem_req) begin
         cap_ma[n_fetch] = mem_addr; n_fetch++;
         rd_cnt = 2; rd_idx = int'(mem_addr[9:3]);
      end
      if (list_done) begin
         ld_cnt++; ld_tag = done_tag; ld_pend = pend;
      end
   end

   function automatic bit xfer_la_changed();
      return (xfer_local_addr != pv_la) || (xfer_ext_addr != pv_ea) || (xfer_size != pv_sz);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic logic [63:0] mk(input vec_t v);
      return {v.halt, 16'h0000, v.size, v.low};
   endfunction

   task automatic send_cmd(input logic dir, input logic [LA_W-1:0] la, input logic [31:0] hi,
                           input logic [LIST_AW-1:0] base, input logic [LEN_W-1:0] bytes,
                           input logic [TAG_W-1:0] tag);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_dir = dir; cmd_local_addr = la; cmd_ext_hi = hi;
      cmd_list_base = base; cmd_list_bytes = bytes; cmd_tag = tag;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic clear_caps();
      n_cap = 0; n_fetch = 0; hold_bad = 0; hold_cycles = 0;
   endtask

   task automatic wait_ld(input int target);
      for (int i = 0; i < 3000 && ld_cnt < target; i++) @(negedge clk);
   endtask

   task automatic wait_stall();
      for (int i = 0; i < 3000 && !stall_evt; i++) @(negedge clk);
      #2;
   endtask

   // check a run of captured sub-transfers against table entries first..first+n-1
   task automatic check_run(input int first, input int n, input logic [LA_W-1:0] la0,
                            input logic [31:0] hi, input logic dir, input logic [TAG_W-1:0] tag,
                            input logic [LIST_AW-1:0] base, input vec_t alt, input int alt_at);
      logic [LA_W-1:0] la;
      la = la0;
      for (int k = 0; k < n; k++) begin
         vec_t v;
         v = (k == alt_at) ? alt : VEC[first + k];
         chk(cap_ma[k] == base + LIST_AW'(8 * k), "R2", "entry read address", cap_ma[k], base + 8 * k);
         chk(cap_ea[k] == {hi, v.low}, "R3", "external address", cap_ea[k], {hi, v.low});
         chk(cap_sz[k] == v.size, (v.size == 15'd16384) ? "R13" : "R3", "size", cap_sz[k], v.size);
         chk(cap_la[k] == la, "R4", "local address", cap_la[k], la);
         chk(cap_dir[k] == dir && cap_tag[k] == tag, "R5", "direction/tag",
             {cap_dir[k], cap_tag[k]}, {dir, tag});
         la = la + LA_W'(v.size);
      end
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      #2;
      // R1: reset state while reset is held
      chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
      chk({mem_req, xfer_valid, stall_evt, list_done} == 4'b0, "R1", "outputs idle in reset",
          {mem_req, xfer_valid, stall_evt, list_done}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(cmd_ready == 1'b1 && !xfer_valid && !mem_req, "R1", "idle after release",
          {cmd_ready, xfer_valid, mem_req}, 3'b100);

      // list A: entries 0..3, throttled ready, completions held back
      for (int k = 0; k < 4; k++) mem[32 + k] = mk(VEC[k]);
      clear_caps();
      ready_mode = 1; done_en = 1'b0;
      send_cmd(1'b1, 18'h00040, 32'hDEAD_BEEF, 18'h00100, 15'd32, 5'd5);
      #2;
      chk(cmd_ready == 1'b0, "R12", "cmd_ready while busy", cmd_ready, 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_tag = 5'd7; cmd_list_bytes = 15'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 3000 && n_cap < 4; i++) @(negedge clk);
      repeat (15) @(negedge clk);
      chk(ld_cnt == 0, "R10", "no done before completions", ld_cnt, 0);
      done_en = 1'b1;
      wait_ld(1);
      repeat (12) @(negedge clk);
      chk(ld_cnt == 1, "R10", "single done pulse", ld_cnt, 1);
      chk(ld_tag == 5'd5, "R12", "done tag unaffected by busy command", ld_tag, 5);
      chk(ld_pend == 0, "R10", "completions outstanding at done", ld_pend, 0);
      chk(n_cap == 4 && n_fetch == 4, "R2", "entry count from byte length",
          n_cap * 16 + n_fetch, 4 * 16 + 4);
      chk(hold_cycles > 0 && hold_bad == 0, "R7", "offer held under backpressure",
          hold_bad, 0);
      check_run(0, 4, 18'h00040, 32'hDEAD_BEEF, 1'b1, 5'd5, 18'h00100, VEC[0], -1);

      // list B: entries 4..6, halt on entry 5, rewrite entry 6 while halted
      for (int k = 0; k < 3; k++) mem[65 + k] = mk(VEC[4 + k]);
      clear_caps();
      ready_mode = 0;
      send_cmd(1'b0, 18'h01000, 32'h0000_0001, 18'h00208, 15'd24, 5'd31);
      wait_stall();
      chk(stall_evt == 1'b1, "R8", "halt raised", stall_evt, 1);
      chk(n_cap == 2 && n_fetch == 2, "R8", "flagged entry issued, next not read",
          n_cap * 16 + n_fetch, 2 * 16 + 2);
      mem[67] = mk('{1'b0, 15'd80, 32'h0000_0200});
      repeat (10) @(negedge clk);
      #2;
      chk(n_fetch == 2 && stall_evt == 1'b1, "R8", "still halted without ack",
          n_fetch * 2 + stall_evt, 5);
      stall_ack = 1'b1;
      @(negedge clk);
      stall_ack = 1'b0;
      wait_ld(2);
      chk(ld_cnt == 2 && ld_tag == 5'd31, "R10", "done for halted list", ld_tag, 31);
      check_run(4, 3, 18'h01000, 32'h0000_0001, 1'b0, 5'd31, 18'h00208,
                '{1'b0, 15'd80, 32'h0000_0200}, 2);
      chk(cap_sz[2] == 15'd80, "R9", "rewritten entry used after ack", cap_sz[2], 80);

      // list C: zero length
      clear_caps();
      send_cmd(1'b1, 18'h00000, 32'h0, 18'h00000, 15'd0, 5'd9);
      wait_ld(3);
      chk(ld_cnt == 3 && ld_tag == 5'd9, "R11", "empty list completes", ld_tag, 9);
      chk(n_fetch == 0 && n_cap == 0, "R11", "no read or transfer", n_fetch + n_cap, 0);

      // list D: single flagged entry is also the last one
      mem[96] = mk('{1'b1, 15'd16, 32'h0000_0330});
      clear_caps();
      send_cmd(1'b1, 18'h00200, 32'h0000_00AB, 18'h00300, 15'd8, 5'd3);
      wait_stall();
      repeat (6) @(negedge clk);
      chk(stall_evt == 1'b1 && ld_cnt == 3, "R8", "halt on last entry holds done",
          ld_cnt, 3);
      stall_ack = 1'b1;
      @(negedge clk);
      stall_ack = 1'b0;
      wait_ld(4);
      chk(ld_cnt == 4 && ld_tag == 5'd3, "R10", "done after last-entry halt", ld_tag, 3);
      chk(n_cap == 1 && cap_ea[0] == 64'h0000_00AB_0000_0330, "R3", "last-entry transfer",
          cap_ea[0], 64'h0000_00AB_0000_0330);
      repeat (4) @(negedge clk);
      #2;
      chk(cmd_ready == 1'b1 && !stall_evt, "R12", "idle again", cmd_ready, 1);

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule